// File: doc/BRIEF.md
# Tag-Matching Operand Wait Station

This block holds a small pool of waiting instructions for one class of functional unit in an out-of-order core. At dispatch, each of an instruction's two source operands arrives in one of two forms. It is either a finished value, or it is the reorder-buffer index of the instruction that will produce that value. Every occupied slot watches the shared result bus. When a slot holds a pending index and a broadcast carries the same index, the slot takes the broadcast value into that operand.

A slot becomes eligible once both of its operands hold values. Each cycle, a selector offers the oldest eligible slot to the functional unit, together with the slot's opcode, both operands and its destination reorder-buffer index. A slot that has been sent stays occupied until its own result appears on the result bus, and only then is it freed. Dispatch stalls when no slot is free or when the reorder buffer reports no free entry. A flush from misprediction recovery empties the pool in one cycle. The functional unit sits outside this block.

Top module: `rs_station`

## Requirements
- R1: `disp_ready` is 1 exactly when at least one slot is free, `disp_rob_free` is 1 and `flush` is 0. An instruction is accepted only in a cycle where `disp_valid` and `disp_ready` are both 1; otherwise nothing is stored.
- R2: For each source operand, `disp_x_rdy`=1 means `disp_x_val` is stored as the operand value. `disp_x_rdy`=0 means `disp_x_tag` is stored as the producer index, and the operand waits.
- R3: A waiting operand whose tag equals `cdb_tag` while `cdb_valid`=1 takes `cdb_val`. The slot can be offered for issue from the following cycle. A broadcast with a different tag changes nothing.
- R4: If a waiting operand is dispatched in the same cycle as a broadcast carrying its tag, the operand is stored with the broadcast value. It does not wait for a later broadcast.
- R5: `issue_valid` is 1 only for a slot whose two operands both hold values. `issue_op`, `issue_a`, `issue_b` and `issue_dst` then present that slot's contents.
- R6: A slot is sent at a rising edge where `issue_valid` and `fu_ready` are both 1. A sent slot is never offered again. With `fu_ready`=0 the offer is held unchanged.
- R7: When several slots are eligible, the one dispatched earliest is offered first, whatever its slot position.
- R8: A sent slot stays occupied until a broadcast whose `cdb_tag` equals its destination index. It is free from the next cycle.
- R9: `flush`=1 empties every slot at the next edge and forces `issue_valid` and `disp_ready` to 0 in that cycle, so a dispatch attempted during the flush is dropped.
- R10: After reset no slot is occupied: `issue_valid` is 0 and `disp_ready` follows `disp_rob_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots (misprediction recovery) |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_rob_free | input | 1 | Reorder buffer has a free entry |
| disp_op | input | 4 | Operation code |
| disp_dst | input | 3 | Destination reorder-buffer index |
| disp_a_rdy | input | 1 | Operand A is a value (1) or a tag (0) |
| disp_a_tag | input | 3 | Producer index of operand A |
| disp_a_val | input | 32 | Value of operand A |
| disp_b_rdy | input | 1 | Operand B is a value (1) or a tag (0) |
| disp_b_tag | input | 3 | Producer index of operand B |
| disp_b_val | input | 32 | Value of operand B |
| cdb_valid | input | 1 | Result bus broadcast valid |
| cdb_tag | input | 3 | Reorder-buffer index of broadcast result |
| cdb_val | input | 32 | Broadcast result value |
| issue_valid | output | 1 | An eligible slot is offered |
| fu_ready | input | 1 | Functional unit takes the offer |
| issue_op | output | 4 | Offered operation code |
| issue_dst | output | 3 | Offered destination index |
| issue_a | output | 32 | Offered operand A |
| issue_b | output | 32 | Offered operand B |

## Verification
Dispatch and result broadcast can fall in the same cycle. The tests provoke this by driving a dispatch whose operand waits on index 6 while the bus carries index 6. The slot must then be offered in the very next cycle holding the broadcast value. A second collision is a result that wakes an older slot in the same cycle a younger, already-complete instruction is written into a lower slot position. The test judges it by which destination index is offered first. A free and a refill can also overlap in adjacent cycles: after a broadcast frees a sent slot, `disp_ready` must rise exactly one cycle later and no sooner.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 3;
    localparam int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } operand_t;

    typedef struct packed {
        op_t      op;
        tag_t     dst;
        operand_t a;
        operand_t b;
    } uop_t;

    // Resolve a waiting operand against a result bus broadcast.
    function automatic operand_t snoop(operand_t o, logic bus_v, tag_t bus_tag, data_t bus_val);
        operand_t r;
        r = o;
        if (!o.rdy && bus_v && (o.tag == bus_tag)) begin
            r.rdy = 1'b1;
            r.val = bus_val;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N = 4
) (
    input  logic [N-1:0] busy,
    output logic [N-1:0] grant,
    output logic         any_free
);
    always_comb begin
        grant    = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !any_free) begin
                grant[i] = 1'b1;
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wr_vec,
    input  logic [N-1:0] ready,
    output logic [N-1:0] sel,
    output logic         sel_any
);
    // older[j][i] = 1 when slot j was written before slot i
    logic [N-1:0] older [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) older[k] <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (wr_vec[k]) begin
                    for (int j = 0; j < N; j++) begin
                        older[k][j] <= 1'b0;
                        if (j != k) older[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older[j][i]) blocked = 1'b1;
            end
            sel[i] = ready[i] && !blocked;
        end
    end

    assign sel_any = |sel;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  wr_en,
    input  uop_t  wr_uop,
    input  logic  cdb_valid,
    input  tag_t  cdb_tag,
    input  data_t cdb_val,
    input  logic  take,
    output logic  busy,
    output logic  sent,
    output logic  ready,
    output uop_t  uop
);
    logic  busy_q, sent_q;
    uop_t  uop_q;
    logic  release_hit;

    assign release_hit = busy_q && sent_q && cdb_valid && (cdb_tag == uop_q.dst);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            uop_q  <= '0;
        end else if (wr_en) begin
            busy_q   <= 1'b1;
            sent_q   <= 1'b0;
            uop_q.op <= wr_uop.op;
            uop_q.dst <= wr_uop.dst;
            uop_q.a  <= snoop(wr_uop.a, cdb_valid, cdb_tag, cdb_val);
            uop_q.b  <= snoop(wr_uop.b, cdb_valid, cdb_tag, cdb_val);
        end else if (busy_q) begin
            if (release_hit) begin
                busy_q <= 1'b0;
                sent_q <= 1'b0;
            end else if (take) begin
                sent_q <= 1'b1;
            end
            uop_q.a <= snoop(uop_q.a, cdb_valid, cdb_tag, cdb_val);
            uop_q.b <= snoop(uop_q.b, cdb_valid, cdb_tag, cdb_val);
        end
    end

    assign busy  = busy_q;
    assign sent  = sent_q;
    assign ready = busy_q && !sent_q && uop_q.a.rdy && uop_q.b.rdy;
    assign uop   = uop_q;
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic              disp_rob_free,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              disp_a_rdy,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic [DATA_W-1:0] disp_a_val,
    input  logic              disp_b_rdy,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [DATA_W-1:0] disp_b_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_val,
    output logic              issue_valid,
    input  logic              fu_ready,
    output logic [OP_W-1:0]   issue_op,
    output logic [TAG_W-1:0]  issue_dst,
    output logic [DATA_W-1:0] issue_a,
    output logic [DATA_W-1:0] issue_b
);
    localparam int DST_FLAT_W = NUM_SLOTS * TAG_W;

    logic [NUM_SLOTS-1:0] busy_vec, sent_vec, ready_vec, sel_vec, grant_vec, wr_vec, take_vec;
    logic                 any_free, sel_any, accept, fire;
    uop_t                 slot_uop [NUM_SLOTS];
    uop_t                 wr_uop, pick;
    logic [DST_FLAT_W-1:0] dst_flat;

    assign wr_uop.op    = disp_op;
    assign wr_uop.dst   = disp_dst;
    assign wr_uop.a.rdy = disp_a_rdy;
    assign wr_uop.a.tag = disp_a_tag;
    assign wr_uop.a.val = disp_a_val;
    assign wr_uop.b.rdy = disp_b_rdy;
    assign wr_uop.b.tag = disp_b_tag;
    assign wr_uop.b.val = disp_b_val;

    rs_alloc #(.N(NUM_SLOTS)) u_alloc (
        .busy     (busy_vec),
        .grant    (grant_vec),
        .any_free (any_free)
    );

    assign disp_ready = any_free && disp_rob_free && !flush;
    assign accept     = disp_valid && disp_ready;
    assign wr_vec     = grant_vec & {NUM_SLOTS{accept}};

    rs_age_select #(.N(NUM_SLOTS)) u_select (
        .clk     (clk),
        .rst     (rst),
        .wr_vec  (wr_vec),
        .ready   (ready_vec),
        .sel     (sel_vec),
        .sel_any (sel_any)
    );

    assign issue_valid = sel_any && !flush;
    assign fire        = issue_valid && fu_ready;
    assign take_vec    = sel_vec & {NUM_SLOTS{fire}};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .wr_en     (wr_vec[g]),
            .wr_uop    (wr_uop),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_val   (cdb_val),
            .take      (take_vec[g]),
            .busy      (busy_vec[g]),
            .sent      (sent_vec[g]),
            .ready     (ready_vec[g]),
            .uop       (slot_uop[g])
        );
        assign dst_flat[g*TAG_W +: TAG_W] = slot_uop[g].dst;
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel_vec[i]) pick = uop_t'(pick | slot_uop[i]);
        end
    end

    assign issue_op  = pick.op;
    assign issue_dst = pick.dst;
    assign issue_a   = pick.a.val;
    assign issue_b   = pick.b.val;
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
#(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           flush,
    input logic           disp_ready,
    input logic           issue_valid,
    input logic           cdb_valid,
    input logic [TAG_W-1:0] cdb_tag,
    input logic [N-1:0]   busy_vec,
    input logic [N-1:0]   sent_vec,
    input logic [N-1:0]   ready_vec,
    input logic [N-1:0]   sel_vec,
    input logic [N*TAG_W-1:0] dst_flat
);
    p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(busy_vec) == N) |-> !disp_ready);

    p_sel_eligible_r5: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> ((sel_vec & ~ready_vec) == '0));

    p_single_offer_r7: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> $onehot(sel_vec));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy_vec == '0));

    for (genvar g = 0; g < N; g++) begin : g_rel
        p_release_r8: assert property (@(posedge clk) disable iff (rst)
            (busy_vec[g] && sent_vec[g] && cdb_valid && !flush &&
             cdb_tag == dst_flat[g*TAG_W +: TAG_W]) |=> !busy_vec[g]);
    end
endmodule

bind rs_station rs_station_chk #(.N(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .disp_ready  (disp_ready),
    .issue_valid (issue_valid),
    .cdb_valid   (cdb_valid),
    .cdb_tag     (cdb_tag),
    .busy_vec    (busy_vec),
    .sent_vec    (sent_vec),
    .ready_vec   (ready_vec),
    .sel_vec     (sel_vec),
    .dst_flat    (dst_flat)
);

// File: tb/rs_station_tb.sv
module rs_station_tb;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst, flush, disp_valid, disp_ready, disp_rob_free;
    logic [OP_W-1:0] disp_op;
    logic [TAG_W-1:0] disp_dst, disp_a_tag, disp_b_tag, cdb_tag, issue_dst;
    logic disp_a_rdy, disp_b_rdy, cdb_valid, issue_valid, fu_ready;
    logic [DATA_W-1:0] disp_a_val, disp_b_val, cdb_val, issue_a, issue_b;
    logic [OP_W-1:0] issue_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rs_station #(.NUM_SLOTS(4)) u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_rob_free(disp_rob_free),
        .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
        .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .issue_valid(issue_valid), .fu_ready(fu_ready),
        .issue_op(issue_op), .issue_dst(issue_dst), .issue_a(issue_a), .issue_b(issue_b)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 1'b0; disp_valid = 1'b0; cdb_valid = 1'b0;
        disp_op = '0; disp_dst = '0;
        disp_a_rdy = 1'b0; disp_a_tag = '0; disp_a_val = '0;
        disp_b_rdy = 1'b0; disp_b_tag = '0; disp_b_val = '0;
        cdb_tag = '0; cdb_val = '0;
    endtask

    task automatic next();
        @(negedge clk);
        idle();
    endtask

    task automatic disp(input int op, input int dst, input bit ar, input int av, input int at,
                        input bit br, input int bv, input int bt);
        disp_valid = 1'b1; disp_op = op[OP_W-1:0]; disp_dst = dst[TAG_W-1:0];
        disp_a_rdy = ar; disp_a_val = av; disp_a_tag = at[TAG_W-1:0];
        disp_b_rdy = br; disp_b_val = bv; disp_b_tag = bt[TAG_W-1:0];
    endtask

    task automatic bcast(input int tag, input int val);
        cdb_valid = 1'b1; cdb_tag = tag[TAG_W-1:0]; cdb_val = val;
    endtask

    task automatic clear_all();
        next();
        flush = 1'b1;
        next();
        fu_ready = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R10", "issue_valid after reset", issue_valid, 0);
        check("R10", "disp_ready after reset", disp_ready, 1);
        disp_rob_free = 1'b0;
        disp(1, 1, 1, 5, 0, 1, 6, 0);
        #1;
        check("R1", "disp_ready without rob entry", disp_ready, 0);
        fu_ready = 1'b1;
        next();
        disp_rob_free = 1'b1;
        #1;
        check("R1", "dropped dispatch not offered", issue_valid, 0);
        clear_all();
    endtask

    task automatic t_basic();
        fu_ready = 1'b1;
        next();
        disp(3, 2, 1, 10, 0, 1, 20, 0);
        next();
        #1;
        check("R5", "issue_valid ready pair", issue_valid, 1);
        check("R2", "issue_a value", issue_a, 10);
        check("R2", "issue_b value", issue_b, 20);
        check("R5", "issue_dst", issue_dst, 2);
        check("R5", "issue_op", issue_op, 3);
        next();
        #1;
        check("R6", "sent slot not offered again", issue_valid, 0);
        clear_all();
    endtask

    task automatic t_wakeup();
        fu_ready = 1'b1;
        next();
        disp(4, 3, 0, 0, 5, 1, 7, 0);
        next();
        #1;
        check("R5", "waiting operand blocks issue", issue_valid, 0);
        bcast(4, 11);
        next();
        #1;
        check("R3", "foreign tag ignored", issue_valid, 0);
        bcast(5, 99);
        #1;
        check("R3", "no issue in broadcast cycle", issue_valid, 0);
        next();
        #1;
        check("R3", "issue after wakeup", issue_valid, 1);
        check("R3", "captured operand a", issue_a, 99);
        check("R2", "kept operand b", issue_b, 7);
        clear_all();
    endtask

    task automatic t_bypass();
        fu_ready = 1'b1;
        next();
        disp(5, 4, 1, 8, 0, 0, 0, 6);
        bcast(6, 55);
        next();
        #1;
        check("R4", "bypass issue_valid", issue_valid, 1);
        check("R4", "bypass operand b", issue_b, 55);
        check("R4", "operand a", issue_a, 8);
        clear_all();
    endtask

    task automatic t_age();
        fu_ready = 1'b0;
        next();
        disp(1, 1, 1, 1, 0, 1, 1, 0);
        next();
        disp(2, 2, 0, 0, 7, 1, 2, 0);
        next();
        #1;
        check("R7", "first offer dst", issue_dst, 1);
        fu_ready = 1'b1;
        next();
        fu_ready = 1'b0;
        bcast(1, 0);
        next();
        disp(3, 3, 1, 3, 0, 1, 3, 0);
        bcast(7, 77);
        next();
        #1;
        check("R7", "older slot wins", issue_dst, 2);
        check("R3", "older slot operand", issue_a, 77);
        fu_ready = 1'b1;
        next();
        #1;
        check("R7", "younger slot next", issue_dst, 3);
        clear_all();
    endtask

    task automatic t_full();
        fu_ready = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            next();
            disp(k, k, 1, k, 0, 1, k, 0);
        end
        next();
        #1;
        check("R1", "disp_ready when full", disp_ready, 0);
        check("R6", "held offer dst", issue_dst, 1);
        fu_ready = 1'b1;
        next();
        fu_ready = 1'b0;
        #1;
        check("R7", "second offer dst", issue_dst, 2);
        check("R8", "sent slot still occupied", disp_ready, 0);
        bcast(1, 0);
        #1;
        check("R8", "not freed in broadcast cycle", disp_ready, 0);
        next();
        #1;
        check("R8", "freed after own broadcast", disp_ready, 1);
        clear_all();
    endtask

    task automatic t_flush();
        fu_ready = 1'b0;
        next();
        disp(6, 5, 1, 1, 0, 1, 2, 0);
        next();
        disp(6, 6, 1, 3, 0, 1, 4, 0);
        next();
        #1;
        check("R9", "offer before flush", issue_valid, 1);
        flush = 1'b1;
        disp(7, 7, 1, 9, 0, 1, 9, 0);
        #1;
        check("R9", "issue_valid during flush", issue_valid, 0);
        check("R9", "disp_ready during flush", disp_ready, 0);
        next();
        #1;
        check("R9", "empty after flush", issue_valid, 0);
        check("R9", "all free after flush", disp_ready, 1);
    endtask

    initial begin
        rst = 1'b1; fu_ready = 1'b0; disp_rob_free = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_wakeup();
        t_bypass();
        t_age();
        t_full();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule